// File: doc/BRIEF.md
# Banked Register File with Linear Address Decoder

This block holds a 64-byte register file and decodes a flat 24-bit byte address space that sits beside it. A register-side port reaches every register location by number. Locations 0 to 7 form a window onto one of four eight-byte banks, chosen by a bank-select input. Locations 8 to 63 are plain registers.

A memory-side port takes 24-bit linear addresses and sends each access to one target. The lowest 32 addresses read and write the bank bytes directly, with every bank visible at once. Memory above that, up to a parameterised size, is general on-chip RAM in region 00:. Reads in region FF: that fall inside the on-chip code size go out through a code-fetch strobe and address, and the byte returned comes back through the data port. Every other address raises an external-access flag. A write aimed at region FF: is refused and raises an error flag.

Both ports write on the rising clock edge and read combinationally. A read therefore sees the stored value from before any write in the same cycle.

Top module: `rf_bank_decoder`

## Requirements
- R1: After reset, every register location in every bank, every bank alias byte and every RAM byte reads as zero.
- R2: A register-port access to location L below 8 reaches bank byte bank_sel*8+L. Locations 8 to 63 reach one shared set of 56 bytes whatever the bank select is.
- R3: A memory-port access to address A in 00:0000H..00:001FH reaches bank A[4:3], register A[2:0], whatever bank_sel is. It is the same storage that the register port reaches through that bank.
- R4: Register locations 8 to 63 are never changed by any memory-port write.
- R5: Memory addresses from 00:0020H up to 00:0020H+RAM_BYTES-1 read and write internal RAM byte A-20H.
- R6: Any other address outside region FF: gives mp_ext=1 and mp_rdata=0 while mp_en is high. A write to such an address changes no internal byte.
- R7: A read in region FF: with a 16-bit offset below CODE_BYTES gives code_sel=1, code_addr equal to the offset and mp_rdata equal to code_rdata. A read in region FF: at or above CODE_BYTES gives mp_ext=1 and code_sel=0.
- R8: A write anywhere in region FF: gives mp_err=1 with mp_ext=0 and code_sel=0, and changes no internal byte.
- R9: When both ports write the same bank byte in one cycle, the register-port data is the value stored.
- R10: A read on either port in the same cycle as a write to the same byte returns the old value. The new value is visible from the next cycle.
- R11: With mp_en low, mp_ext, mp_err and code_sel are 0 and a memory-port write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all storage |
| bank_sel | input | 2 | Bank shown at register locations 0..7 |
| rp_addr | input | 6 | Register location number |
| rp_wr | input | 1 | Register-port write enable |
| rp_wdata | input | 8 | Register-port write data |
| rp_rdata | output | 8 | Register-port read data (combinational) |
| mp_en | input | 1 | Memory-port access valid |
| mp_wr | input | 1 | Memory-port write (1) or read (0) |
| mp_addr | input | 24 | Linear byte address |
| mp_wdata | input | 8 | Memory-port write data |
| mp_rdata | output | 8 | Memory-port read data (combinational) |
| mp_ext | output | 1 | Access belongs to external memory |
| mp_err | output | 1 | Refused write to the code region |
| code_sel | output | 1 | Read goes to on-chip code memory |
| code_addr | output | 16 | Offset inside the code region |
| code_rdata | input | 8 | Byte returned by code memory |

## Verification
The hardest case to reach from the ports is a same-cycle write from both ports to one bank byte. The register port names it through the current bank select, while the memory port names it by absolute address. The bench sweeps every bank and register pair, and for each one it computes the matching linear address from the bank number and register index. It then drives both writes in the same cycle with different data and reads the byte back through both ports. The same alignment is used to read the aliased byte during a single-port write, which shows that the old value comes back until the edge.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

   localparam int RFD_ADDR_W   = 24;
   localparam int RFD_DATA_W   = 8;
   localparam int RFD_OFFS_W   = 16;
   localparam logic [7:0] RFD_CODE_REGION = 8'hFF;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_BANK,
      RGN_RAM,
      RGN_CODE,
      RGN_EXT,
      RGN_ERR
   } rfd_region_e;

endpackage

// File: rtl/rfd_addr_decode.sv
module rfd_addr_decode
   import rfd_pkg::*;
#(
   parameter int BANK_BYTES = 32,
   parameter int RAM_BYTES  = 224,
   parameter int CODE_BYTES = 4096,
   parameter int BANK_IW    = 5,
   parameter int RAM_AW     = 8
) (
   input  logic                  en,
   input  logic                  wr,
   input  logic [RFD_ADDR_W-1:0] addr,
   output rfd_region_e           region,
   output logic [BANK_IW-1:0]    bank_idx,
   output logic [RAM_AW-1:0]     ram_idx,
   output logic [RFD_OFFS_W-1:0] code_off
);

   localparam logic [RFD_ADDR_W-1:0] BANK_LIM_A = RFD_ADDR_W'(BANK_BYTES);
   localparam logic [RFD_ADDR_W-1:0] RAM_LIM_A  = RFD_ADDR_W'(BANK_BYTES + RAM_BYTES);
   localparam logic [RFD_OFFS_W:0]   CODE_LIM_A = (RFD_OFFS_W+1)'(CODE_BYTES);

   logic in_code_region;
   logic code_hit;
   logic [RFD_ADDR_W-1:0] ram_off;

   assign in_code_region = (addr[RFD_ADDR_W-1:RFD_OFFS_W] == RFD_CODE_REGION);
   assign code_hit       = ({1'b0, addr[RFD_OFFS_W-1:0]} < CODE_LIM_A);
   assign ram_off        = addr - BANK_LIM_A;

   assign bank_idx = addr[BANK_IW-1:0];
   assign ram_idx  = ram_off[RAM_AW-1:0];
   assign code_off = addr[RFD_OFFS_W-1:0];

   always_comb begin
      region = RGN_NONE;
      if (en) begin
         if (in_code_region) begin
            if (wr)            region = RGN_ERR;
            else if (code_hit) region = RGN_CODE;
            else               region = RGN_EXT;
         end else if (addr < BANK_LIM_A) begin
            region = RGN_BANK;
         end else if ((RAM_BYTES > 0) && (addr < RAM_LIM_A)) begin
            region = RGN_RAM;
         end else begin
            region = RGN_EXT;
         end
      end
   end

endmodule

// File: rtl/rfd_bank_array.sv
module rfd_bank_array #(
   parameter int ENTRIES = 32,
   parameter int IW      = 5,
   parameter int DW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wa_en,
   input  logic [IW-1:0] wa_idx,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [IW-1:0] wb_idx,
   input  logic [DW-1:0] wb_data,
   input  logic [IW-1:0] ra_idx,
   output logic [DW-1:0] ra_data,
   input  logic [IW-1:0] rb_idx,
   output logic [DW-1:0] rb_data
);

   logic [DW-1:0] q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) q[i] <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wa_en && (wa_idx == IW'(i)))      q[i] <= wa_data;
            else if (wb_en && (wb_idx == IW'(i))) q[i] <= wb_data;
         end
      end
   end

   assign ra_data = q[ra_idx];
   assign rb_data = q[rb_idx];

endmodule

// File: rtl/rfd_byte_ram.sv
module rfd_byte_ram #(
   parameter int DEPTH = 56,
   parameter int AW    = 6,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   localparam logic [AW:0] DEPTH_A = (AW+1)'(DEPTH);

   logic [DW-1:0] q [DEPTH];
   logic          wr_ok;
   logic          rd_ok;

   assign wr_ok = wr_en && ({1'b0, wr_idx} < DEPTH_A);
   assign rd_ok = ({1'b0, rd_idx} < DEPTH_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      end else if (wr_ok) begin
         for (int i = 0; i < DEPTH; i++)
            if (wr_idx == AW'(i)) q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++)
         if (rd_ok && (rd_idx == AW'(i))) rd_data = q[i];
   end

endmodule

// File: rtl/rf_bank_decoder.sv
module rf_bank_decoder
   import rfd_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int BANK_REGS  = 8,
   parameter int RF_LOCS    = 64,
   parameter int RAM_BYTES  = 224,
   parameter int CODE_BYTES = 4096
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(NUM_BANKS)-1:0] bank_sel,
   input  logic [$clog2(RF_LOCS)-1:0]   rp_addr,
   input  logic                         rp_wr,
   input  logic [7:0]                   rp_wdata,
   output logic [7:0]                   rp_rdata,
   input  logic                         mp_en,
   input  logic                         mp_wr,
   input  logic [23:0]                  mp_addr,
   input  logic [7:0]                   mp_wdata,
   output logic [7:0]                   mp_rdata,
   output logic                         mp_ext,
   output logic                         mp_err,
   output logic                         code_sel,
   output logic [15:0]                  code_addr,
   input  logic [7:0]                   code_rdata
);

   localparam int BANK_AW    = $clog2(NUM_BANKS);
   localparam int REG_AW     = $clog2(BANK_REGS);
   localparam int LOC_AW     = $clog2(RF_LOCS);
   localparam int BANK_BYTES = NUM_BANKS * BANK_REGS;
   localparam int BANK_IW    = BANK_AW + REG_AW;
   localparam int UPPER      = RF_LOCS - BANK_REGS;
   localparam int RAM_AW     = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (BANK_REGS < 2 || (BANK_REGS & (BANK_REGS - 1)) != 0) begin : g_bad_regs
      $error("BANK_REGS must be a power of two, at least 2");
   end
   if (RF_LOCS <= BANK_REGS || (1 << LOC_AW) != RF_LOCS) begin : g_bad_locs
      $error("RF_LOCS must be a power of two above BANK_REGS");
   end
   if (CODE_BYTES < 1 || CODE_BYTES > 65536) begin : g_bad_code
      $error("CODE_BYTES must lie in 1..65536");
   end
   if (RAM_BYTES < 0 || BANK_BYTES + RAM_BYTES > 65536) begin : g_bad_ram
      $error("bank bytes plus RAM must fit in region 00");
   end

   // register-side index formation
   logic                rp_in_win;
   logic [BANK_IW-1:0]  rp_bank_idx;
   logic [LOC_AW-1:0]   rp_up_idx;
   logic [7:0]          rp_bank_rd;
   logic [7:0]          rp_up_rd;

   assign rp_in_win   = (rp_addr < LOC_AW'(BANK_REGS));
   assign rp_bank_idx = {bank_sel, rp_addr[REG_AW-1:0]};
   assign rp_up_idx   = rp_addr - LOC_AW'(BANK_REGS);
   assign rp_rdata    = rp_in_win ? rp_bank_rd : rp_up_rd;

   // memory-side decode
   rfd_region_e         mp_region;
   logic [BANK_IW-1:0]  mp_bank_idx;
   logic [RAM_AW-1:0]   mp_ram_idx;
   logic [15:0]         mp_code_off;
   logic [7:0]          mp_bank_rd;
   logic [7:0]          mp_ram_rd;

   rfd_addr_decode #(
      .BANK_BYTES (BANK_BYTES),
      .RAM_BYTES  (RAM_BYTES),
      .CODE_BYTES (CODE_BYTES),
      .BANK_IW    (BANK_IW),
      .RAM_AW     (RAM_AW)
   ) u_dec (
      .en       (mp_en),
      .wr       (mp_wr),
      .addr     (mp_addr),
      .region   (mp_region),
      .bank_idx (mp_bank_idx),
      .ram_idx  (mp_ram_idx),
      .code_off (mp_code_off)
   );

   // bank storage: register port on write port A (higher priority)
   rfd_bank_array #(
      .ENTRIES (BANK_BYTES),
      .IW      (BANK_IW),
      .DW      (8)
   ) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (rp_wr && rp_in_win),
      .wa_idx  (rp_bank_idx),
      .wa_data (rp_wdata),
      .wb_en   (mp_wr && (mp_region == RGN_BANK)),
      .wb_idx  (mp_bank_idx),
      .wb_data (mp_wdata),
      .ra_idx  (rp_bank_idx),
      .ra_data (rp_bank_rd),
      .rb_idx  (mp_bank_idx),
      .rb_data (mp_bank_rd)
   );

   // registers above the bank window: register port only
   rfd_byte_ram #(
      .DEPTH (UPPER),
      .AW    (LOC_AW),
      .DW    (8)
   ) u_upper (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rp_wr && !rp_in_win),
      .wr_idx  (rp_up_idx),
      .wr_data (rp_wdata),
      .rd_idx  (rp_up_idx),
      .rd_data (rp_up_rd)
   );

   // general RAM, present only when sized
   if (RAM_BYTES > 0) begin : g_ram
      rfd_byte_ram #(
         .DEPTH (RAM_BYTES),
         .AW    (RAM_AW),
         .DW    (8)
      ) u_ram (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (mp_wr && (mp_region == RGN_RAM)),
         .wr_idx  (mp_ram_idx),
         .wr_data (mp_wdata),
         .rd_idx  (mp_ram_idx),
         .rd_data (mp_ram_rd)
      );
   end else begin : g_no_ram
      assign mp_ram_rd = '0;
   end

   // memory-side result steering
   always_comb begin
      unique case (mp_region)
         RGN_BANK: mp_rdata = mp_bank_rd;
         RGN_RAM:  mp_rdata = mp_ram_rd;
         RGN_CODE: mp_rdata = code_rdata;
         default:  mp_rdata = '0;
      endcase
   end

   assign mp_ext    = (mp_region == RGN_EXT);
   assign mp_err    = (mp_region == RGN_ERR);
   assign code_sel  = (mp_region == RGN_CODE);
   assign code_addr = mp_code_off;

endmodule

// File: rtl/rfd_checker.sv
module rfd_checker #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_REGS = 8,
   parameter int RF_LOCS   = 64
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [$clog2(NUM_BANKS)-1:0] bank_sel,
   input logic [$clog2(RF_LOCS)-1:0]   rp_addr,
   input logic                         rp_wr,
   input logic [7:0]                   rp_wdata,
   input logic [7:0]                   rp_rdata,
   input logic                         mp_en,
   input logic                         mp_wr,
   input logic [23:0]                  mp_addr,
   input logic [7:0]                   mp_rdata,
   input logic                         mp_ext,
   input logic                         mp_err,
   input logic                         code_sel
);

   localparam int BANK_AW = $clog2(NUM_BANKS);
   localparam int REG_AW  = $clog2(BANK_REGS);
   localparam int LOC_AW  = $clog2(RF_LOCS);
   localparam int IW      = BANK_AW + REG_AW;

   logic          rp_win;
   logic          mp_alias;
   logic [IW-1:0] rp_idx;
   logic          same_byte;
   logic          coll_q;
   logic [IW-1:0] coll_idx_q;
   logic [7:0]    coll_data_q;

   assign rp_win    = (rp_addr < LOC_AW'(BANK_REGS));
   assign mp_alias  = mp_en && (mp_addr < 24'(NUM_BANKS * BANK_REGS));
   assign rp_idx    = {bank_sel, rp_addr[REG_AW-1:0]};
   assign same_byte = rp_win && mp_alias && (mp_addr[IW-1:0] == rp_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coll_q      <= 1'b0;
         coll_idx_q  <= '0;
         coll_data_q <= '0;
      end else begin
         coll_q      <= same_byte && rp_wr && mp_wr;
         coll_idx_q  <= rp_idx;
         coll_data_q <= rp_wdata;
      end
   end

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mp_ext, mp_err, code_sel}) <= 1);                          // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mp_en |-> (!mp_ext && !mp_err && !code_sel));                         // R11

   AST_ERR_ONLY_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mp_err |-> (mp_wr && mp_addr[23:16] == 8'hFF));                        // R8

   AST_CODE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      code_sel |-> (!mp_wr && mp_addr[23:16] == 8'hFF));                     // R7

   AST_ALIAS_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      same_byte |-> (mp_rdata == rp_rdata));                                 // R3

   AST_REG_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_q && rp_win && rp_idx == coll_idx_q) |-> (rp_rdata == coll_data_q)); // R9

endmodule

bind rf_bank_decoder rfd_checker #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_REGS (BANK_REGS),
   .RF_LOCS   (RF_LOCS)
) u_rfd_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bank_sel (bank_sel),
   .rp_addr  (rp_addr),
   .rp_wr    (rp_wr),
   .rp_wdata (rp_wdata),
   .rp_rdata (rp_rdata),
   .mp_en    (mp_en),
   .mp_wr    (mp_wr),
   .mp_addr  (mp_addr),
   .mp_rdata (mp_rdata),
   .mp_ext   (mp_ext),
   .mp_err   (mp_err),
   .code_sel (code_sel)
);

// File: tb/rf_bank_decoder_bench.sv
`timescale 1ns/1ps
module rf_bank_decoder_bench;

   localparam int RAMB  = 224;
   localparam int CODEB = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bank_sel = '0;
   logic [5:0]  rp_addr = '0;
   logic        rp_wr = 1'b0;
   logic [7:0]  rp_wdata = '0;
   logic [7:0]  rp_rdata;
   logic        mp_en = 1'b0;
   logic        mp_wr = 1'b0;
   logic [23:0] mp_addr = '0;
   logic [7:0]  mp_wdata = '0;
   logic [7:0]  mp_rdata;
   logic        mp_ext;
   logic        mp_err;
   logic        code_sel;
   logic [15:0] code_addr;
   logic [7:0]  code_rdata;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   logic [7:0] m_bank [32];
   logic [7:0] m_up   [56];
   logic [7:0] m_ram  [RAMB];

   always #4 clk = ~clk;

   assign code_rdata = code_addr[7:0] ^ code_addr[15:8] ^ 8'hA5;

   rf_bank_decoder #(.RAM_BYTES(RAMB), .CODE_BYTES(CODEB)) u_rf_bank_decoder (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
      .rp_addr(rp_addr), .rp_wr(rp_wr), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata),
      .mp_en(mp_en), .mp_wr(mp_wr), .mp_addr(mp_addr), .mp_wdata(mp_wdata),
      .mp_rdata(mp_rdata), .mp_ext(mp_ext), .mp_err(mp_err),
      .code_sel(code_sel), .code_addr(code_addr), .code_rdata(code_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] reg_val(input int b, input int loc);
      return 8'((b * 64 + loc) * 7 + 3);
   endfunction

   // register port read: set, settle, sample (inputs change at negedge)
   task automatic rp_read(input int b, input int loc, output logic [7:0] v);
      bank_sel = 2'(b); rp_addr = 6'(loc); #1; v = rp_rdata;
   endtask

   task automatic mp_read(input logic [23:0] a, output logic [7:0] v);
      mp_en = 1; mp_wr = 0; mp_addr = a; #1; v = mp_rdata;
   endtask

   task automatic rp_write(input int b, input int loc, input logic [7:0] v);
      bank_sel = 2'(b); rp_addr = 6'(loc); rp_wdata = v; rp_wr = 1;
      @(negedge clk); rp_wr = 0;
      if (loc < 8) m_bank[b * 8 + loc] = v; else m_up[loc - 8] = v;
   endtask

   task automatic mp_write_nomodel(input logic [23:0] a, input logic [7:0] v);
      mp_en = 1; mp_wr = 1; mp_addr = a; mp_wdata = v;
      @(negedge clk); mp_wr = 0; mp_en = 0;
   endtask

   task automatic expect_mem(input logic [23:0] a, input string req);
      logic [7:0] v;
      mp_read(a, v);
      if (a < 24'h20) chk(req, v, m_bank[a[4:0]]);
      else            chk(req, v, m_ram[int'(a) - 32]);
      mp_en = 0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++; vectors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < 32; i++) m_bank[i] = '0;
      for (int i = 0; i < 56; i++) m_up[i] = '0;
      for (int i = 0; i < RAMB; i++) m_ram[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state through both ports
      for (int b = 0; b < 4; b++)
         for (int l = 0; l < 64; l++) begin rp_read(b, l, v); chk("R1 reg", v, 0); end
      for (int a = 0; a < 32 + RAMB; a++) begin mp_read(24'(a), v); chk("R1 mem", v, 0); end
      mp_en = 0;

      // R2: register port writes in every bank, then readback
      for (int b = 0; b < 4; b++)
         for (int l = 0; l < 64; l++) rp_write(b, l, reg_val(b, l));
      for (int b = 0; b < 4; b++)
         for (int l = 0; l < 64; l++) begin
            rp_read(b, l, v);
            chk("R2 reg", v, (l < 8) ? m_bank[b * 8 + l] : m_up[l - 8]);
         end

      // R3: alias read independent of bank_sel, then alias write seen by register port
      for (int a = 0; a < 32; a++) begin
         bank_sel = 2'(a ^ 3);
         mp_read(24'(a), v); chk("R3 read", v, m_bank[a]);
      end
      mp_en = 0;
      for (int a = 0; a < 32; a++) begin
         bank_sel = 2'(~a);
         mp_write_nomodel(24'(a), 8'(a * 13 + 90));
         m_bank[a] = 8'(a * 13 + 90);
      end
      for (int a = 0; a < 32; a++) begin rp_read(a / 8, a % 8, v); chk("R3 reg", v, m_bank[a]); end

      // R5: RAM fill and readback
      for (int a = 32; a < 32 + RAMB; a++) begin
         mp_write_nomodel(24'(a), 8'(a * 5 + 1));
         m_ram[a - 32] = 8'(a * 5 + 1);
      end
      for (int a = 32; a < 32 + RAMB; a++) expect_mem(24'(a), "R5");

      // R6: external addresses
      for (int a = 32 + RAMB; a < 512; a++) begin
         mp_read(24'(a), v);
         chk("R6 ext", mp_ext, 1); chk("R6 data", v, 0); chk("R6 noerr", mp_err, 0);
      end
      for (int r = 1; r < 255; r++) begin
         mp_read({8'(r), 8'(r * 3), 8'(r)}, v);
         chk("R6 ext region", mp_ext, 1); chk("R6 code", code_sel, 0);
      end
      mp_en = 0;
      for (int r = 0; r < 8; r++) mp_write_nomodel({8'(r * 31), 16'h0100 + 16'(r)}, 8'hEE);
      mp_write_nomodel(24'h010005, 8'hEE);
      mp_write_nomodel(24'h010025, 8'hEE);
      for (int a = 0; a < 32 + RAMB; a++) expect_mem(24'(a), "R6 untouched");

      // R4: upper registers unchanged by all memory writes so far
      for (int l = 8; l < 64; l++) begin rp_read(l % 4, l, v); chk("R4", v, m_up[l - 8]); end

      // R7: code region reads
      for (int o = 0; o < CODEB; o++) begin
         mp_read({8'hFF, 16'(o)}, v);
         chk("R7 sel", code_sel, 1); chk("R7 addr", code_addr, o);
         chk("R7 data", v, 8'(o) ^ 8'(o >> 8) ^ 8'hA5); chk("R7 noext", mp_ext, 0);
      end
      mp_read(24'hFF1000, v); chk("R7 beyond ext", mp_ext, 1); chk("R7 beyond sel", code_sel, 0);
      mp_read(24'hFFFFFF, v); chk("R7 top ext", mp_ext, 1); chk("R7 top sel", code_sel, 0);
      mp_en = 0;

      // R8: writes to code region refused
      foreach (m_bank[i]) if (i == 0) ;
      for (int k = 0; k < 3; k++) begin
         logic [23:0] a;
         a = (k == 0) ? 24'hFF0005 : (k == 1) ? 24'hFF0025 : 24'hFF1000;
         mp_en = 1; mp_wr = 1; mp_addr = a; mp_wdata = 8'h3C; #1;
         chk("R8 err", mp_err, 1); chk("R8 noext", mp_ext, 0); chk("R8 nosel", code_sel, 0);
         @(negedge clk); mp_wr = 0; mp_en = 0;
      end
      expect_mem(24'h000005, "R8 bank");
      expect_mem(24'h000025, "R8 ram");

      // R9: collisions on every bank byte, register port wins
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 8; r++) begin
            bank_sel = 2'(b); rp_addr = 6'(r); rp_wdata = 8'(b * 8 + r + 100); rp_wr = 1;
            mp_en = 1; mp_wr = 1; mp_addr = 24'(b * 8 + r); mp_wdata = 8'h77;
            @(negedge clk); rp_wr = 0; mp_wr = 0; mp_en = 0;
            m_bank[b * 8 + r] = 8'(b * 8 + r + 100);
            rp_read(b, r, v); chk("R9 reg", v, m_bank[b * 8 + r]);
            expect_mem(24'(b * 8 + r), "R9 mem");
         end
      // simultaneous writes to different bytes both land
      bank_sel = 2'd1; rp_addr = 6'd2; rp_wdata = 8'h11; rp_wr = 1;
      mp_en = 1; mp_wr = 1; mp_addr = 24'h000013; mp_wdata = 8'h22;
      @(negedge clk); rp_wr = 0; mp_wr = 0; mp_en = 0;
      m_bank[10] = 8'h11; m_bank[19] = 8'h22;
      expect_mem(24'h00000A, "R9 split a");
      expect_mem(24'h000013, "R9 split b");

      // R10: old value during write, new value after the edge
      for (int b = 0; b < 4; b++) begin
         bank_sel = 2'(b); rp_addr = 6'd5; rp_wdata = 8'(200 + b); rp_wr = 1;
         mp_en = 1; mp_wr = 0; mp_addr = 24'(b * 8 + 5); #1;
         chk("R10 old mem", mp_rdata, m_bank[b * 8 + 5]);
         chk("R10 old reg", rp_rdata, m_bank[b * 8 + 5]);
         @(negedge clk); rp_wr = 0; #1;
         m_bank[b * 8 + 5] = 8'(200 + b);
         chk("R10 new mem", mp_rdata, m_bank[b * 8 + 5]);
         mp_en = 0;
      end
      mp_en = 1; mp_wr = 1; mp_addr = 24'h000030; mp_wdata = 8'h9D; #1;
      chk("R10 ram old", mp_rdata, m_ram[16]);
      @(negedge clk); mp_wr = 0; #1; m_ram[16] = 8'h9D;
      chk("R10 ram new", mp_rdata, m_ram[16]);
      mp_en = 0;

      // R11: disabled memory port
      for (int k = 0; k < 4; k++) begin
         logic [23:0] a;
         a = (k == 0) ? 24'h000010 : (k == 1) ? 24'h000040 : (k == 2) ? 24'hFF0001 : 24'h123456;
         mp_en = 0; mp_wr = 1; mp_addr = a; mp_wdata = 8'h5F; #1;
         chk("R11 ext", mp_ext, 0); chk("R11 err", mp_err, 0); chk("R11 sel", code_sel, 0);
         @(negedge clk); mp_wr = 0;
      end
      expect_mem(24'h000010, "R11 bank");
      expect_mem(24'h000040, "R11 ram");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule